// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatcher

This block turns an interrupt command into a per-target accept vector for a set of N local interrupt controllers. The command has two 32-bit words. The upper word carries the destination byte. The lower word carries the vector, the delivery mode, the destination mode, the level and trigger bits, and a two-bit shorthand. Writing the lower word starts a dispatch. One clock later the block presents a one-cycle valid strobe together with the set of targets that accept the interrupt.

Each target supplies its own configuration through ports:
- an 8-bit physical identifier,
- an 8-bit logical identifier,
- a 4-bit logical format code,
- an enable flag.

Targets are matched by shorthand, by physical identifier, or by logical identifier in either flat or cluster format. For lowest-priority delivery, exactly one target is picked. The pick rotates among the targets that both match and are enabled. The block only selects targets. Queuing the interrupt at each target is left to the receivers, which decode the vector and mode fields from the stored lower command word.

Top module: `ipi_dispatch`

## Requirements
- R1: A high `cmd_lo_wr` at a clock edge makes `accept_valid` high for exactly the following cycle, with `accept_vec` holding that dispatch's result. Whenever `accept_valid` is low, `accept_vec` is all zeros.
- R2: The shorthand is lower-word bits [19:18]:
  - 0 uses destination matching;
  - 1 selects only the sender `src_idx`;
  - 2 selects every target;
  - 3 selects every target except the sender.
- R3: The destination is the byte in upper-word bits [31:24], and `cmd_hi_q` keeps only those bits, with the rest zero. With shorthand 0 and lower-word bit 11 = 0 (physical), a target matches when the destination is 0xFF or equals its physical identifier.
- R4: With bit 11 = 1 (logical) and a target format code of 4'hF (flat), the target matches when its logical identifier AND the destination is nonzero.
- R5: With bit 11 = 1 and format code 4'h0 (cluster), the target matches when the upper nibbles of its logical identifier and the destination are equal and the AND of their lower nibbles is nonzero.
- R6: A logical-mode command never matches a target whose format code is neither 4'hF nor 4'h0.
- R7: For every delivery mode (lower-word bits [10:8]) other than 3'b001, all matched targets accept, regardless of their enable flags.
- R8: Delivery mode 3'b001 (lowest priority) works as follows:
  - It scans the targets from one past the previously chosen index, wrapping around, and accepts only the first target that is both matched and enabled.
  - That target becomes the new previous index.
  - If no target qualifies, the strobe still occurs with an all-zero vector, and the previous index is unchanged.
- R9: The previous index resets to N-1, so the first lowest-priority pick after reset tries target 0 first. Non-lowest dispatches leave it unchanged.
- R10: `cmd_lo_q` stores the last lower word written, with bit 12 (send pending) always zero. Both stored words reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_hi_wr | input | 1 | Upper command word write strobe |
| cmd_hi_din | input | 32 | Upper command word data |
| cmd_lo_wr | input | 1 | Lower command word write strobe; starts a dispatch |
| cmd_lo_din | input | 32 | Lower command word data |
| src_idx | input | IDXW | Index of the sending target |
| tgt_phys_id | input | N*8 | Physical identifiers, target i at [8i+7:8i] |
| tgt_log_id | input | N*8 | Logical identifiers, target i at [8i+7:8i] |
| tgt_fmt | input | N*4 | Logical format codes, target i at [4i+3:4i] |
| tgt_en | input | N | Per-target enable flags |
| cmd_lo_q | output | 32 | Stored lower command word |
| cmd_hi_q | output | 32 | Stored upper command word |
| accept_valid | output | 1 | Dispatch result strobe |
| accept_vec | output | N | Per-target accept flags |

## Verification
The bench builds the block with N=6. Because six is not a power of two, the round-robin wrap from index 5 back to 0 goes through true modulo arithmetic, not a free-running counter overflow. Six targets are also enough to give cluster groups with more than one member, a pair of disabled targets between enabled ones, and a sender in the middle of the range, so the excluding shorthand has targets on both sides.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [2:0] DM_LOWEST   = 3'b001;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;

  function automatic logic phys_hit(input logic [7:0] dest, input logic [7:0] id);
    return (dest == DEST_BCAST) || (dest == id);
  endfunction

  function automatic logic logical_hit(input logic [7:0] dest, input logic [7:0] lid,
                                       input logic [3:0] fmt);
    logic r;
    case (fmt)
      FMT_FLAT:    r = (lid & dest) != 8'h00;
      FMT_CLUSTER: r = (lid[7:4] == dest[7:4]) && ((lid[3:0] & dest[3:0]) != 4'h0);
      default:     r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ipi_match.sv
module ipi_match
  import ipi_pkg::*;
#(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [7:0]      dest,
  input  logic            dest_logical,
  input  logic [1:0]      shorthand,
  input  logic [IDXW-1:0] src,
  input  logic [N*8-1:0]  phys_ids,
  input  logic [N*8-1:0]  log_ids,
  input  logic [N*4-1:0]  fmts,
  output logic [N-1:0]    hit
);

  for (genvar g = 0; g < N; g++) begin : g_tgt
    logic addr_hit;
    logic is_src;

    assign is_src   = (src == IDXW'(g));
    assign addr_hit = dest_logical ? logical_hit(dest, log_ids[g*8 +: 8], fmts[g*4 +: 4])
                                   : phys_hit(dest, phys_ids[g*8 +: 8]);

    always_comb begin
      case (shorthand_e'(shorthand))
        SH_DEST:   hit[g] = addr_hit;
        SH_SELF:   hit[g] = is_src;
        SH_ALL:    hit[g] = 1'b1;
        SH_OTHERS: hit[g] = !is_src;
        default:   hit[g] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    cand,
  input  logic [IDXW-1:0] prev,
  output logic [N-1:0]    pick,
  output logic [IDXW-1:0] pick_idx,
  output logic            found
);

  always_comb begin
    found    = 1'b0;
    pick_idx = prev;
    for (int off = 1; off <= N; off++) begin
      if (!found && cand[(int'(prev) + off) % N]) begin
        found    = 1'b1;
        pick_idx = IDXW'((int'(prev) + off) % N);
      end
    end
    pick = '0;
    if (found) pick[pick_idx] = 1'b1;
  end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_hi_wr,
  input  logic [31:0]     cmd_hi_din,
  input  logic            cmd_lo_wr,
  input  logic [31:0]     cmd_lo_din,
  input  logic [IDXW-1:0] src_idx,
  input  logic [N*8-1:0]  tgt_phys_id,
  input  logic [N*8-1:0]  tgt_log_id,
  input  logic [N*4-1:0]  tgt_fmt,
  input  logic [N-1:0]    tgt_en,
  output logic [31:0]     cmd_lo_q,
  output logic [31:0]     cmd_hi_q,
  output logic            accept_valid,
  output logic [N-1:0]    accept_vec
);

  localparam int PEND_BIT = 12;

  // Named internal events, visible to the bound checker
  logic [N-1:0]    hit;
  logic [N-1:0]    cand;
  logic [N-1:0]    pick;
  logic [IDXW-1:0] pick_idx;
  logic            pick_found;
  logic            lowest_sel;
  logic [IDXW-1:0] rr_prev;
  logic [N-1:0]    next_vec;

  assign lowest_sel = (cmd_lo_din[10:8] == DM_LOWEST);
  assign cand       = hit & tgt_en;
  assign next_vec   = lowest_sel ? pick : hit;

  ipi_match #(.N(N)) u_match (
    .dest         (cmd_hi_q[31:24]),
    .dest_logical (cmd_lo_din[11]),
    .shorthand    (cmd_lo_din[19:18]),
    .src          (src_idx),
    .phys_ids     (tgt_phys_id),
    .log_ids      (tgt_log_id),
    .fmts         (tgt_fmt),
    .hit          (hit)
  );

  ipi_rr_pick #(.N(N)) u_rr (
    .cand     (cand),
    .prev     (rr_prev),
    .pick     (pick),
    .pick_idx (pick_idx),
    .found    (pick_found)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_lo_q     <= '0;
      cmd_hi_q     <= '0;
      accept_valid <= 1'b0;
      accept_vec   <= '0;
      rr_prev      <= IDXW'(N - 1);
    end else begin
      accept_valid <= cmd_lo_wr;
      accept_vec   <= cmd_lo_wr ? next_vec : '0;
      if (cmd_hi_wr) cmd_hi_q <= {cmd_hi_din[31:24], 24'h0};
      if (cmd_lo_wr) cmd_lo_q <= cmd_lo_din & ~(32'd1 << PEND_BIT);
      if (cmd_lo_wr && lowest_sel && pick_found) rr_prev <= pick_idx;
    end
  end

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_lo_wr,
  input logic [31:0]     cmd_lo_din,
  input logic [IDXW-1:0] src_idx,
  input logic [N-1:0]    tgt_en,
  input logic [31:0]     cmd_lo_q,
  input logic            accept_valid,
  input logic [N-1:0]    accept_vec,
  input logic            lowest_sel,
  input logic [IDXW-1:0] rr_prev
);

  // R1
  fire_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lo_wr |=> accept_valid);

  // R1
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lo_wr |=> !accept_valid);

  // R1
  quiet_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_valid |-> (accept_vec == '0));

  // R2
  others_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_wr && cmd_lo_din[19:18] == 2'd3) |=> !accept_vec[$past(src_idx)]);

  // R8
  lowest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_wr && lowest_sel) |=> $onehot0(accept_vec));

  // R8
  lowest_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_wr && lowest_sel) |=> ((accept_vec & ~$past(tgt_en)) == '0));

  // R9
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_lo_wr && lowest_sel) |=> $stable(rr_prev));

  // R10
  pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lo_q[12] == 1'b0);

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.N(N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_lo_wr    (cmd_lo_wr),
  .cmd_lo_din   (cmd_lo_din),
  .src_idx      (src_idx),
  .tgt_en       (tgt_en),
  .cmd_lo_q     (cmd_lo_q),
  .accept_valid (accept_valid),
  .accept_vec   (accept_vec),
  .lowest_sel   (lowest_sel),
  .rr_prev      (rr_prev)
);

// File: tb/tb_ipi_dispatch.sv
`timescale 1ns/1ps
module tb_ipi_dispatch;
  localparam int N = 6;
  localparam int IDXW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_hi_wr = 1'b0;
  logic [31:0]     cmd_hi_din = '0;
  logic            cmd_lo_wr = 1'b0;
  logic [31:0]     cmd_lo_din = '0;
  logic [IDXW-1:0] src_idx = '0;
  logic [N*8-1:0]  tgt_phys_id;
  logic [N*8-1:0]  tgt_log_id;
  logic [N*4-1:0]  tgt_fmt;
  logic [N-1:0]    tgt_en;
  logic [31:0]     cmd_lo_q, cmd_hi_q;
  logic            accept_valid;
  logic [N-1:0]    accept_vec;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipi_dispatch #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_hi_wr(cmd_hi_wr), .cmd_hi_din(cmd_hi_din),
    .cmd_lo_wr(cmd_lo_wr), .cmd_lo_din(cmd_lo_din), .src_idx(src_idx),
    .tgt_phys_id(tgt_phys_id), .tgt_log_id(tgt_log_id), .tgt_fmt(tgt_fmt),
    .tgt_en(tgt_en), .cmd_lo_q(cmd_lo_q), .cmd_hi_q(cmd_hi_q),
    .accept_valid(accept_valid), .accept_vec(accept_vec)
  );

  function automatic logic [31:0] mk_lo(input logic [1:0] sh, input logic logical,
                                        input logic [2:0] mode, input logic [7:0] vec);
    logic [31:0] w;
    w = '0;
    w[19:18] = sh;
    w[11] = logical;
    w[10:8] = mode;
    w[7:0] = vec;
    return w;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_dest(input logic [31:0] hi);
    @(negedge clk);
    cmd_hi_din = hi; cmd_hi_wr = 1'b1;
    @(negedge clk);
    cmd_hi_wr = 1'b0;
  endtask

  // drives the lower word for one edge and checks the strobe and vector after it
  task automatic dispatch(input string req, input logic [31:0] lo, input logic [N-1:0] exp);
    @(negedge clk);
    cmd_lo_din = lo; cmd_lo_wr = 1'b1;
    @(negedge clk);
    cmd_lo_wr = 1'b0;
    check32(req, {31'd0, accept_valid}, 32'd1);
    check32(req, {26'd0, accept_vec}, {26'd0, exp});
  endtask

  task automatic t_reset();
    check32("R1 reset valid", {31'd0, accept_valid}, 32'd0);
    check32("R1 reset vec", {26'd0, accept_vec}, 32'd0);
    check32("R10 reset lo", cmd_lo_q, 32'd0);
    check32("R10 reset hi", cmd_hi_q, 32'd0);
  endtask

  task automatic t_physical();
    set_dest(32'h0412_3456);
    check32("R3 hi masked", cmd_hi_q, 32'h0400_0000);
    dispatch("R3 phys id 4", mk_lo(2'd0, 1'b0, 3'b000, 8'h40), 6'b000100);
    @(negedge clk);
    check32("R1 strobe one cycle", {31'd0, accept_valid}, 32'd0);
    check32("R1 vec cleared", {26'd0, accept_vec}, 32'd0);
    set_dest(32'hFF00_0000);
    dispatch("R3 broadcast", mk_lo(2'd0, 1'b0, 3'b000, 8'h41), 6'b111111);
    set_dest(32'h0700_0000);
    dispatch("R3 no match", mk_lo(2'd0, 1'b0, 3'b000, 8'h42), 6'b000000);
  endtask

  task automatic t_flat();
    set_dest(32'h0500_0000);
    dispatch("R4 flat", mk_lo(2'd0, 1'b1, 3'b000, 8'h50), 6'b000101);
  endtask

  task automatic t_cluster();
    tgt_fmt = '0;
    tgt_log_id = {8'h31, 8'h14, 8'h22, 8'h21, 8'h12, 8'h11};
    set_dest(32'h1300_0000);
    dispatch("R5 cluster 1", mk_lo(2'd0, 1'b1, 3'b000, 8'h60), 6'b000011);
    set_dest(32'h2F00_0000);
    dispatch("R5 cluster 2", mk_lo(2'd0, 1'b1, 3'b000, 8'h61), 6'b001100);
  endtask

  task automatic t_badfmt();
    tgt_fmt = {N{4'h5}};
    set_dest(32'hFF00_0000);
    dispatch("R6 bad format", mk_lo(2'd0, 1'b1, 3'b000, 8'h70), 6'b000000);
    tgt_fmt = {N{4'hF}};
  endtask

  task automatic t_shorthand();
    set_dest(32'h0700_0000);
    src_idx = 3'd3;
    dispatch("R2 self", mk_lo(2'd1, 1'b0, 3'b000, 8'h80), 6'b001000);
    dispatch("R2 all", mk_lo(2'd2, 1'b0, 3'b000, 8'h81), 6'b111111);
    dispatch("R2 others", mk_lo(2'd3, 1'b0, 3'b000, 8'h82), 6'b110111);
  endtask

  task automatic t_pending();
    logic [31:0] w;
    w = mk_lo(2'd2, 1'b0, 3'b100, 8'h93) | 32'h0000_D000;
    dispatch("R10 dispatch", w, 6'b111111);
    check32("R10 pend cleared", cmd_lo_q, w & ~32'h0000_1000);
  endtask

  task automatic t_fixed_ignores_en();
    tgt_en = '0;
    set_dest(32'hFF00_0000);
    dispatch("R7 fixed disabled", mk_lo(2'd0, 1'b0, 3'b000, 8'hA0), 6'b111111);
    tgt_en = '1;
  endtask

  task automatic t_first_pick();
    set_dest(32'hFF00_0000);
    dispatch("R9 first pick t0", mk_lo(2'd0, 1'b0, 3'b001, 8'hB0), 6'b000001);
  endtask

  task automatic t_rotate();
    dispatch("R8 next t1", mk_lo(2'd0, 1'b0, 3'b001, 8'hB1), 6'b000010);
    tgt_en = 6'b110011;
    dispatch("R8 skip disabled", mk_lo(2'd0, 1'b0, 3'b001, 8'hB2), 6'b010000);
    dispatch("R8 t5", mk_lo(2'd0, 1'b0, 3'b001, 8'hB3), 6'b100000);
    dispatch("R8 wrap t0", mk_lo(2'd0, 1'b0, 3'b001, 8'hB4), 6'b000001);
    tgt_en = '0;
    dispatch("R8 none", mk_lo(2'd0, 1'b0, 3'b001, 8'hB5), 6'b000000);
    tgt_en = '1;
    dispatch("R8 prev kept", mk_lo(2'd0, 1'b0, 3'b001, 8'hB6), 6'b000010);
    set_dest(32'h0400_0000);
    dispatch("R8 single match", mk_lo(2'd0, 1'b0, 3'b001, 8'hB7), 6'b000100);
    src_idx = 3'd3;
    dispatch("R8 skip sender", mk_lo(2'd3, 1'b0, 3'b001, 8'hB8), 6'b010000);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      tgt_phys_id[i*8 +: 8] = 8'(2 * i);
      tgt_log_id[i*8 +: 8]  = 8'(1 << i);
      tgt_fmt[i*4 +: 4]     = 4'hF;
    end
    tgt_en = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_physical();
    t_flat();
    t_cluster();
    t_badfmt();
    t_shorthand();
    t_pending();
    t_fixed_ignores_en();
    t_first_pick();
    t_rotate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule